// File: doc/BRIEF.md
# Two-Channel Monitor ADC Register Target

This block is the serial-peripheral side of a two-channel current and voltage monitor. A host reaches it over a four-wire SPI link in mode 0. The block holds a sparse bank of byte-wide registers behind a 16-bit address space. The bank has configuration registers, fixed identity bytes, a ready flag and four result bytes. The two 12-bit measurements enter on parallel ports, and the block publishes them as big-endian byte pairs.

A transaction opens with chip-select going low. The first two bytes carry the address, most significant bit first, and the top address bit selects a read. Every further byte is a data byte. After each data byte the working address steps down by one, so a burst that starts at the top result byte reads the current pair and then the voltage pair in a single frame. A new sample pair is captured only when one frame has read all four result bytes, in descending order, down to the lowest one. Any shorter or misordered read leaves the published pair as it was. The host can therefore never see the high and low bytes of two different samples mixed together.

The SPI pins are brought into the system clock domain by two-stage synchronisers. The system clock must run several times faster than the serial clock.

Top module: `spiadc_target`

## Requirements
- R1: A frame is the time that `spi_cs_n` is low. MOSI is sampled on the rising serial clock edge and MISO changes after the falling edge. The first two bytes form the address, and bit 15 set (0x80 in the first byte) marks a read. MISO is 0 whenever chip-select is high.
- R2: After reset, the byte at 0x0000 is 0x99, and the bytes at 0x0001, 0x000F and 0x0100 are 0x00.
- R3: Address 0x0006 returns the revision parameter (default 0x02). Addresses 0x000C and 0x000D return the two identity parameters (defaults 0x5A and 0xA5). Addresses 0x0002 to 0x0005 return 0x00.
- R4: Any address outside 0x0000–0x0006, 0x000C–0x000D, 0x000F, 0x0100, 0x0103 and 0x0200–0x0203 reads as 0x00.
- R5: Only 0x0000, 0x0001, 0x000F and 0x0100 accept writes. A write to any other address changes nothing that can be read back.
- R6: After every data byte, read or write, the working address decreases by one.
- R7: Address 0x0103 reads 0x00 for READY_CYCLES clock cycles after reset is released, and 0x01 from then on.
- R8: The result bytes are laid out as follows: 0x0203 holds the current sample bits 11:8 with zeros above, 0x0202 holds current bits 7:0, 0x0201 holds voltage bits 11:8 and 0x0200 holds voltage bits 7:0. All four read 0x00 after reset.
- R9: When one frame reads 0x0203, 0x0202, 0x0201 and 0x0200 in sequence, the sample inputs are captured at the end of the 0x0200 byte. Reads of the result bytes after that return the captured values.
- R10: A frame that ends before 0x0200 is read, or that does not start its result run at 0x0203, leaves the published results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| volt_sample | input | SAMPLE_W | Voltage measurement to capture |
| curr_sample | input | SAMPLE_W | Current measurement to capture |

## Verification
The checker watches several properties on every cycle. MISO must be quiet outside a frame, and the configuration bytes must hold their defaults on the first cycle after reset. Writes to protected addresses must leave the writable bytes untouched, and the working address must fall by exactly one after each data byte. The ready flag must never drop once set, and the published results may change only in the cycle the capture fires. Some behaviour can only be shown by the bench's frames: the byte layout seen on MISO, the lag of one complete read before new samples appear, and the rejection of short or misordered result reads. The bench checks these against values it derives from the sample inputs it drives.

// File: rtl/spiadc_pkg.sv
// Package: register addresses, frame phase type and access-range helpers
// shared by the register target and its checker.
package spiadc_pkg;

    localparam logic [15:0] A_CFG_A  = 16'h0000;
    localparam logic [15:0] A_CFG_B  = 16'h0001;
    localparam logic [15:0] A_REV    = 16'h0006;
    localparam logic [15:0] A_ID_LO  = 16'h000C;
    localparam logic [15:0] A_ID_HI  = 16'h000D;
    localparam logic [15:0] A_UPD    = 16'h000F;
    localparam logic [15:0] A_CTRL   = 16'h0100;
    localparam logic [15:0] A_STAT   = 16'h0103;
    localparam logic [15:0] A_V_LO   = 16'h0200;
    localparam logic [15:0] A_V_HI   = 16'h0201;
    localparam logic [15:0] A_I_LO   = 16'h0202;
    localparam logic [15:0] A_I_HI   = 16'h0203;

    localparam logic [7:0]  CFG_A_DEFAULT = 8'h99;

    typedef enum logic [1:0] {PH_ADDR_HI, PH_ADDR_LO, PH_DATA} phase_e;

    // True for every address that returns stored or fixed contents.
    function automatic logic addr_readable(input logic [15:0] a);
        return (a <= A_REV) || (a == A_ID_LO) || (a == A_ID_HI) ||
               (a == A_UPD) || (a == A_CTRL) || (a == A_STAT) ||
               ((a >= A_V_LO) && (a <= A_I_HI));
    endfunction

    // True only for the four bytes the host may modify.
    function automatic logic addr_writable(input logic [15:0] a);
        return (a == A_CFG_A) || (a == A_CFG_B) || (a == A_UPD) || (a == A_CTRL);
    endfunction

endpackage

// File: rtl/spiadc_shift.sv
// Serial byte engine for SPI mode 0.
// Brings SCLK, CS_N and MOSI into the clk domain through two-flop
// synchronisers. It assembles receive bytes on rising edges and shifts the
// transmit byte out on falling edges.
// Assumes clk is at least about eight times faster than SCLK.
// rx_byte is valid in the cycle byte_done is high; a load in that cycle
// supplies the next byte to send.
module spiadc_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       load_en,
    input  logic [7:0] load_byte,
    output logic       miso,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       frame_end
);

    logic [2:0] sclk_q;
    logic [2:0] cs_q;
    logic [1:0] mosi_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       rise;
    logic       fall;

    // Synchronise the serial pins and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign active    = ~cs_q[1];
    assign frame_end = cs_q[1] & ~cs_q[2];
    assign rise      = active & sclk_q[1] & ~sclk_q[2];
    assign fall      = active & ~sclk_q[1] & sclk_q[2];
    assign rx_byte   = {rx_sr, mosi_q[1]};
    assign byte_done = rise & (bit_cnt == 3'd7);
    assign miso      = tx_sr[7];

    // Count bits and collect MOSI on each rising edge within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sr   <= rx_byte[6:0];
        end
    end

    // Load or shift the transmit byte. The falling edge that follows a byte
    // boundary leaves the freshly loaded MSB in place.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tx_sr <= '0;
        end else if (load_en) begin
            tx_sr <= load_byte;
        end else if (fall && bit_cnt != 3'd0) begin
            tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end

endmodule

// File: rtl/spiadc_regs.sv
// Register bank: configuration bytes, fixed identity bytes, the ready
// counter, the published result pair and the descending-read tracker
// that decides when to capture a new sample pair.
// Assumes the caller reports each completed data byte once through
// rd_done or wr_en, and reports the end of each frame through frame_end.
module spiadc_regs
    import spiadc_pkg::*;
#(
    parameter int         READY_CYCLES = 1000,
    parameter int         SAMPLE_W     = 12,
    parameter logic [7:0] REV_VAL      = 8'h02,
    parameter logic [7:0] ID_LO_VAL    = 8'h5A,
    parameter logic [7:0] ID_HI_VAL    = 8'h A5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         rd_addr,
    output logic [7:0]          rd_data,
    input  logic [15:0]         acc_addr,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic                rd_done,
    input  logic                frame_end,
    input  logic [SAMPLE_W-1:0] volt_in,
    input  logic [SAMPLE_W-1:0] curr_in,
    output logic                ready_o,
    output logic                latch_o,
    output logic [31:0]         cfg_o,
    output logic [31:0]         res_o
);

    localparam int CNT_W = $clog2(READY_CYCLES + 1);

    logic [CNT_W-1:0]    rdy_cnt;
    logic                ready;
    logic [7:0]          cfg_a, cfg_b, upd, ctrl;
    logic [SAMPLE_W-1:0] v_res, i_res;
    logic [15:0]         v_ext, i_ext;
    logic [1:0]          seq_pos;
    logic                latch_now;

    // Hold the ready flag low for READY_CYCLES cycles after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_cnt <= '0;
            ready   <= 1'b0;
        end else if (!ready) begin
            if (rdy_cnt == CNT_W'(READY_CYCLES - 1)) ready <= 1'b1;
            else rdy_cnt <= rdy_cnt + 1'b1;
        end
    end

    // Accept host writes to the four writable bytes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_a <= CFG_A_DEFAULT;
            cfg_b <= 8'h00;
            upd   <= 8'h00;
            ctrl  <= 8'h00;
        end else if (wr_en) begin
            case (acc_addr)
                A_CFG_A: cfg_a <= wr_data;
                A_CFG_B: cfg_b <= wr_data;
                A_UPD:   upd   <= wr_data;
                A_CTRL:  ctrl  <= wr_data;
                default: ;
            endcase
        end
    end

    // Track how far the current frame has read down the result bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end || wr_en) begin
            seq_pos <= 2'd0;
        end else if (rd_done) begin
            if (acc_addr == A_I_HI)                        seq_pos <= 2'd1;
            else if (seq_pos == 2'd1 && acc_addr == A_I_LO) seq_pos <= 2'd2;
            else if (seq_pos == 2'd2 && acc_addr == A_V_HI) seq_pos <= 2'd3;
            else                                           seq_pos <= 2'd0;
        end
    end

    assign latch_now = rd_done && (acc_addr == A_V_LO) && (seq_pos == 2'd3);

    // Capture a new sample pair once a complete descending read finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_res <= '0;
            i_res <= '0;
        end else if (latch_now) begin
            v_res <= volt_in;
            i_res <= curr_in;
        end
    end

    assign v_ext = 16'(v_res);
    assign i_ext = 16'(i_res);

    // Return the byte at rd_addr; unreadable addresses give zero.
    always_comb begin
        rd_data = 8'h00;
        if (addr_readable(rd_addr)) begin
            case (rd_addr)
                A_CFG_A: rd_data = cfg_a;
                A_CFG_B: rd_data = cfg_b;
                A_REV:   rd_data = REV_VAL;
                A_ID_LO: rd_data = ID_LO_VAL;
                A_ID_HI: rd_data = ID_HI_VAL;
                A_UPD:   rd_data = upd;
                A_CTRL:  rd_data = ctrl;
                A_STAT:  rd_data = {7'd0, ready};
                A_V_LO:  rd_data = v_ext[7:0];
                A_V_HI:  rd_data = v_ext[15:8];
                A_I_LO:  rd_data = i_ext[7:0];
                A_I_HI:  rd_data = i_ext[15:8];
                default: rd_data = 8'h00;
            endcase
        end
    end

    assign ready_o = ready;
    assign latch_o = latch_now;
    assign cfg_o   = {cfg_a, cfg_b, upd, ctrl};
    assign res_o   = {i_ext, v_ext};

endmodule

// File: rtl/spiadc_target.sv
// Top of the monitor ADC register target.
// Frames SPI bytes into two address bytes followed by data bytes, and steps
// the working address down after every data byte. It drives reads and
// writes into the register bank and feeds MISO with the next byte to read.
// Assumes clk runs well above the serial clock (see spiadc_shift).
module spiadc_target
    import spiadc_pkg::*;
#(
    parameter int         READY_CYCLES = 1000,
    parameter int         SAMPLE_W     = 12,
    parameter logic [7:0] REV_VAL      = 8'h02,
    parameter logic [7:0] ID_LO_VAL    = 8'h5A,
    parameter logic [7:0] ID_HI_VAL    = 8'hA5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sclk,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic [SAMPLE_W-1:0] volt_sample,
    input  logic [SAMPLE_W-1:0] curr_sample
);

    phase_e      phase;
    logic [7:0]  addr_hi;
    logic        rd_mode;
    logic [15:0] cur_addr;
    logic [15:0] lo_addr;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic [7:0]  rx_byte;
    logic        active, byte_done, frame_end;
    logic        load_en, data_done, rd_done, wr_en;
    logic        ready_o, latch_o;
    logic [31:0] cfg_o, res_o;

    spiadc_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .load_en   (load_en),
        .load_byte (rd_data),
        .miso      (spi_miso),
        .active    (active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .frame_end (frame_end)
    );

    assign lo_addr   = {1'b0, addr_hi[6:0], rx_byte};
    assign rd_addr   = (phase == PH_ADDR_LO) ? lo_addr : cur_addr - 16'd1;
    assign data_done = byte_done && (phase == PH_DATA);
    assign rd_done   = data_done && rd_mode;
    assign wr_en     = data_done && !rd_mode;
    assign load_en   = byte_done && (((phase == PH_ADDR_LO) && addr_hi[7]) ||
                                     ((phase == PH_DATA) && rd_mode));

    // Walk the frame phases and step the working address down after each data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_ADDR_HI;
            addr_hi  <= '0;
            rd_mode  <= 1'b0;
            cur_addr <= '0;
        end else if (!active) begin
            phase <= PH_ADDR_HI;
        end else if (byte_done) begin
            case (phase)
                PH_ADDR_HI: begin
                    addr_hi <= rx_byte;
                    phase   <= PH_ADDR_LO;
                end
                PH_ADDR_LO: begin
                    cur_addr <= lo_addr;
                    rd_mode  <= addr_hi[7];
                    phase    <= PH_DATA;
                end
                default: cur_addr <= cur_addr - 16'd1;
            endcase
        end
    end

    spiadc_regs #(
        .READY_CYCLES (READY_CYCLES),
        .SAMPLE_W     (SAMPLE_W),
        .REV_VAL      (REV_VAL),
        .ID_LO_VAL    (ID_LO_VAL),
        .ID_HI_VAL    (ID_HI_VAL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .acc_addr  (cur_addr),
        .wr_en     (wr_en),
        .wr_data   (rx_byte),
        .rd_done   (rd_done),
        .frame_end (frame_end),
        .volt_in   (volt_sample),
        .curr_in   (curr_sample),
        .ready_o   (ready_o),
        .latch_o   (latch_o),
        .cfg_o     (cfg_o),
        .res_o     (res_o)
    );

endmodule

// File: rtl/spiadc_target_chk.sv
// Checker for spiadc_target, attached through bind. It observes the frame
// state, the register bank outputs and MISO.
module spiadc_target_chk
    import spiadc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        active,
    input logic        spi_miso,
    input logic        wr_en,
    input logic        data_done,
    input logic [15:0] cur_addr,
    input logic        ready_o,
    input logic        latch_o,
    input logic [31:0] cfg_o,
    input logic [31:0] res_o
);

    // R1: MISO goes quiet once the frame is over.
    p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !spi_miso);

    // R2: configuration bytes hold their defaults right after reset.
    p_cfg_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg_o == {CFG_A_DEFAULT, 24'h000000}));

    // R5: a write to a protected address leaves every writable byte alone.
    p_ro_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_writable(cur_addr)) |=> $stable(cfg_o));

    // R6: each data byte moves the working address down by one.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> (cur_addr == $past(cur_addr) - 16'd1));

    // R7: once ready, the status flag stays set.
    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R10: published results change only when a capture fires.
    p_hold_results_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_o |=> $stable(res_o));

endmodule

bind spiadc_target spiadc_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .spi_miso  (spi_miso),
    .wr_en     (wr_en),
    .data_done (data_done),
    .cur_addr  (cur_addr),
    .ready_o   (ready_o),
    .latch_o   (latch_o),
    .cfg_o     (cfg_o),
    .res_o     (res_o)
);

// File: tb/spiadc_target_tb.sv
// Bench for spiadc_target. It walks a table of single-byte reads, then runs
// directed frames for writes, bursts, sample capture and reset.
module spiadc_target_tb;

    localparam int HALF = 8;   // system cycles per serial half-period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [11:0] volt = '0;
    logic [11:0] curr = '0;

    int total = 0;
    int bad   = 0;
    logic [7:0] rbuf [0:7];
    logic [7:0] wbuf [0:7];

    always #10 clk = ~clk;

    spiadc_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .volt_sample (volt),
        .curr_sample (curr)
    );

    // Table entries: {requirement number, address, expected byte}.
    localparam logic [31:0] VEC [0:12] = '{
        {8'd2,  16'h0000, 8'h99},   // R2
        {8'd2,  16'h0001, 8'h00},   // R2
        {8'd2,  16'h000F, 8'h00},   // R2
        {8'd2,  16'h0100, 8'h00},   // R2
        {8'd3,  16'h0006, 8'h02},   // R3
        {8'd3,  16'h000C, 8'h5A},   // R3
        {8'd3,  16'h000D, 8'hA5},   // R3
        {8'd3,  16'h0004, 8'h00},   // R3
        {8'd4,  16'h0007, 8'h00},   // R4
        {8'd4,  16'h0104, 8'h00},   // R4
        {8'd4,  16'h0204, 8'h00},   // R4
        {8'd8,  16'h0203, 8'h00},   // R8
        {8'd8,  16'h0200, 8'h00}    // R8
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_txn(input logic [15:0] addr, input int n, input logic is_rd);
        logic [15:0] hdr;
        logic [7:0]  junk;
        hdr = {is_rd, addr[14:0]};
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_byte(hdr[15:8], junk);
        spi_byte(hdr[7:0], junk);
        for (int i = 0; i < n; i++) spi_byte(is_rd ? 8'h00 : wbuf[i], rbuf[i]);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr1(input logic [15:0] addr, input logic [7:0] d);
        wbuf[0] = d;
        spi_txn(addr, 1, 1'b0);
    endtask

    task automatic rd_result4(input logic [7:0] e3, input logic [7:0] e2,
                              input logic [7:0] e1, input logic [7:0] e0, input string req);
        spi_txn(16'h0203, 4, 1'b1);
        chk(req, rbuf[0], e3);
        chk(req, rbuf[1], e2);
        chk(req, rbuf[2], e1);
        chk(req, rbuf[3], e0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        chk("R1", {7'd0, miso}, 8'h00);      // quiet during reset
        rst_n = 1'b1;
        @(negedge clk);

        // R7: status reads 0 shortly after reset, then 1
        spi_txn(16'h0103, 1, 1'b1);
        chk("R7", rbuf[0], 8'h00);
        repeat (1100) @(negedge clk);
        spi_txn(16'h0103, 1, 1'b1);
        chk("R7", rbuf[0], 8'h01);

        // Table of single-byte reads
        for (int k = 0; k < 13; k++) begin
            spi_txn(VEC[k][23:8], 1, 1'b1);
            chk($sformatf("R%0d", VEC[k][31:24]), rbuf[0], VEC[k][7:0]);
        end

        // R5: writable bytes update, protected bytes do not
        wr1(16'h0001, 8'h3C);
        spi_txn(16'h0001, 1, 1'b1);  chk("R5", rbuf[0], 8'h3C);
        wr1(16'h0100, 8'h77);
        spi_txn(16'h0100, 1, 1'b1);  chk("R5", rbuf[0], 8'h77);
        wr1(16'h0006, 8'hFF);
        spi_txn(16'h0006, 1, 1'b1);  chk("R5", rbuf[0], 8'h02);
        wr1(16'h0103, 8'h00);
        spi_txn(16'h0103, 1, 1'b1);  chk("R5", rbuf[0], 8'h01);
        wr1(16'h0002, 8'h55);
        spi_txn(16'h0002, 1, 1'b1);  chk("R5", rbuf[0], 8'h00);

        // R6: burst write and burst read both step downward
        wbuf[0] = 8'h12;
        wbuf[1] = 8'h34;
        spi_txn(16'h0001, 2, 1'b0);
        spi_txn(16'h0001, 2, 1'b1);
        chk("R6", rbuf[0], 8'h12);
        chk("R6", rbuf[1], 8'h34);
        spi_txn(16'h000D, 2, 1'b1);
        chk("R6", rbuf[0], 8'hA5);
        chk("R6", rbuf[1], 8'h5A);
        chk("R1", {7'd0, miso}, 8'h00);       // quiet after a read frame

        // R9: first full read returns reset results and captures inputs
        volt = 12'hABC;
        curr = 12'h123;
        rd_result4(8'h00, 8'h00, 8'h00, 8'h00, "R9");
        rd_result4(8'h01, 8'h23, 8'h0A, 8'hBC, "R8");

        // R10: short and misordered reads do not capture
        volt = 12'h456;
        curr = 12'h789;
        spi_txn(16'h0203, 3, 1'b1);
        chk("R10", rbuf[2], 8'h0A);
        spi_txn(16'h0202, 3, 1'b1);
        chk("R10", rbuf[0], 8'h23);
        chk("R10", rbuf[2], 8'hBC);
        rd_result4(8'h01, 8'h23, 8'h0A, 8'hBC, "R10");
        rd_result4(8'h07, 8'h89, 8'h04, 8'h56, "R9");

        // R2: a reset mid-run restores defaults and clears results
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        spi_txn(16'h0001, 2, 1'b1);
        chk("R2", rbuf[0], 8'h00);
        chk("R2", rbuf[1], 8'h99);
        spi_txn(16'h0203, 1, 1'b1);
        chk("R8", rbuf[0], 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule